// File: doc/BRIEF.md
# USB Device Common Event Flag Register

This block collects the device-wide bus events of a USB function controller into one 8-bit status register. Four sticky flags record a start-of-frame, a bus reset, a resume and a suspend. A bus-signalling detector supplies each event as a single-cycle pulse. The block also receives the current suspend state and a suspend-detect enable. A combined interrupt request stays high while any flag is set. Firmware services the events by reading the register, and that read clears every flag at once.

A frame timer stands in for a lost start-of-frame token. It starts on the first real token after reset and measures one frame period, given as a parameter in clock cycles. The default is 48000 cycles, which is 1 ms at 48 MHz. Each received token restarts the period. If a period ends with no token, the timer raises the start-of-frame flag itself and begins the next period. The timer goes idle on a bus reset and on entry into suspend, and it waits for the next real token before it runs again.

The register decodes at one address of the USB register space. The read port has one cycle of latency. An event that lands in the same cycle as a clearing read is kept: it shows up in the flags after the read.

Top module: `usb_evt_flags`

## Requirements
- R1: The register answers at address `REG_ADDR` (default 0x06), and bits 7:4 of its read data are always 0. A read at any other address returns 0 and leaves the flags unchanged.
- R2: The flag layout is: bit 3 start-of-frame, bit 2 bus reset, bit 1 resume, bit 0 suspend. After reset all four flags are 0 and the interrupt request is low.
- R3: When `rd_en_i` is high at `REG_ADDR` on a clock edge, `rd_data_o` holds the flag values from before that edge, starting in the following cycle. All flags are cleared at that same edge.
- R4: An event pulse in the same cycle as a clearing read is not lost. Its flag is set after the edge, and the read still returns the older values.
- R5: A `bus_rst_i` pulse sets the bus-reset flag, whatever the suspend state is.
- R6: A `resume_i` pulse sets the resume flag only while `in_suspend_i` is high. At other times it is ignored.
- R7: A `suspend_sig_i` pulse sets the suspend flag only while `susp_det_en_i` is high. At other times it is ignored.
- R8: A `sof_tok_i` pulse sets the start-of-frame flag. The frame timer stays idle after reset until the first token, so it raises no flag before that token.
- R9: When `FRAME_CYCLES` cycles pass after the edge that takes the last token, with no new token, the start-of-frame flag is set. This repeats every `FRAME_CYCLES` cycles, and any new token restarts the count.
- R10: A bus reset, or a rising edge of `in_suspend_i`, stops the frame timer. No start-of-frame flag is then raised until another token arrives.
- R11: `irq_o` is high in exactly the cycles in which at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_tok_i | input | 1 | One-cycle pulse: start-of-frame token received |
| bus_rst_i | input | 1 | One-cycle pulse: reset signalling detected |
| resume_i | input | 1 | One-cycle pulse: resume signalling detected |
| suspend_sig_i | input | 1 | One-cycle pulse: suspend signalling detected |
| in_suspend_i | input | 1 | Device is currently suspended |
| susp_det_en_i | input | 1 | Suspend detection enabled |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | DATA_W | Read data, valid the cycle after the strobe |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench drives every input just after a falling edge and samples just after the next rising edge or falling edge, so each result is checked in the cycle it is due. A flag and `irq_o` change at the first rising edge after an event pulse. Read data appears at the edge that takes the strobe, and that same edge clears the flags. A missed-token flag appears at the edge exactly `FRAME_CYCLES` edges after the edge that took the token. The monitor notes a strobe at the rising edge and compares `rd_data_o` one time unit later against the next entry in the scoreboard queue. Checks on `irq_o` are placed one cycle before and one cycle after each predicted expiry, so an off-by-one timer period is caught.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;
   localparam int FLAG_N  = 4;
   localparam int IDX_SUS = 0;
   localparam int IDX_RSU = 1;
   localparam int IDX_RST = 2;
   localparam int IDX_SOF = 3;
   typedef logic [FLAG_N-1:0] evt_vec_t;
endpackage

// File: rtl/usb_frame_timer.sv
module usb_frame_timer #(
   parameter int FRAME_CYCLES = 48000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tok_i,
   input  logic halt_i,
   output logic miss_o,
   output logic run_o
);
   localparam int CNT_W = (FRAME_CYCLES > 2) ? $clog2(FRAME_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CYCLES - 1);

   if (FRAME_CYCLES < 2) begin : g_bad_period
      $error("usb_frame_timer: FRAME_CYCLES must be at least 2");
   end

   logic             run_q;
   logic [CNT_W-1:0] cnt_q;
   logic             at_end;

   assign at_end = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (halt_i) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (tok_i) begin
         run_q <= 1'b1;
         cnt_q <= '0;
      end else if (run_q) begin
         if (at_end) cnt_q <= '0;
         else        cnt_q <= cnt_q + 1'b1;
      end
   end

   assign miss_o = run_q && at_end && !tok_i && !halt_i;
   assign run_o  = run_q;

   AST_HALT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
      halt_i |=> !run_q); // R10
   AST_TOKEN_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_i && !halt_i) |=> (run_q && cnt_q == '0)); // R8
   AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST); // R9
   AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !tok_i) |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/usb_evt_flag_bank.sv
module usb_evt_flag_bank
   import usb_evt_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  evt_vec_t set_i,
   input  logic     clr_i,
   output evt_vec_t flags_o
);
   evt_vec_t flag_q;

   for (genvar i = 0; i < FLAG_N; i++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q[i] <= 1'b0;
         else        flag_q[i] <= set_i[i] | (flag_q[i] & ~clr_i);
      end

      AST_SET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> flag_q[i]); // R4
      AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_q[i] && !clr_i) |=> flag_q[i]); // R3
   end

   assign flags_o = flag_q;

   AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && set_i == '0) |=> (flag_q == '0)); // R3
endmodule

// File: rtl/usb_evt_flags.sv
module usb_evt_flags
   import usb_evt_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 8,
   parameter int REG_ADDR     = 6,
   parameter int FRAME_CYCLES = 48000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sof_tok_i,
   input  logic              bus_rst_i,
   input  logic              resume_i,
   input  logic              suspend_sig_i,
   input  logic              in_suspend_i,
   input  logic              susp_det_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              irq_o
);
   localparam int PAD_W = DATA_W - FLAG_N;
   localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

   if (DATA_W <= FLAG_N) begin : g_bad_width
      $error("usb_evt_flags: DATA_W must exceed the flag count");
   end
   if (REG_ADDR < 0 || REG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("usb_evt_flags: REG_ADDR does not fit in ADDR_W bits");
   end

   logic     susp_q;
   logic     halt;
   logic     miss;
   logic     tmr_run;
   logic     rd_hit;
   evt_vec_t set_vec;
   evt_vec_t flags;
   logic [DATA_W-1:0] rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) susp_q <= 1'b0;
      else        susp_q <= in_suspend_i;
   end

   assign halt = bus_rst_i | (in_suspend_i & ~susp_q);

   usb_frame_timer #(.FRAME_CYCLES(FRAME_CYCLES)) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tok_i  (sof_tok_i),
      .halt_i (halt),
      .miss_o (miss),
      .run_o  (tmr_run)
   );

   always_comb begin
      set_vec          = '0;
      set_vec[IDX_SOF] = sof_tok_i | miss;
      set_vec[IDX_RST] = bus_rst_i;
      set_vec[IDX_RSU] = resume_i & in_suspend_i;
      set_vec[IDX_SUS] = suspend_sig_i & susp_det_en_i;
   end

   assign rd_hit = rd_en_i && (rd_addr_i == MY_ADDR);

   usb_evt_flag_bank i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (set_vec),
      .clr_i   (rd_hit),
      .flags_o (flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_q <= '0;
      else if (rd_hit)  rd_q <= {{PAD_W{1'b0}}, flags};
      else if (rd_en_i) rd_q <= '0;
   end

   assign rd_data_o = rd_q;
   assign irq_o     = |flags;

   AST_READ_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |=> (rd_data_o[FLAG_N-1:0] == $past(flags))); // R3
   AST_FOREIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && !rd_hit) |=> (rd_data_o == '0 && (flags & $past(flags)) == $past(flags))); // R1
   AST_RST_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst_i |=> flags[IDX_RST]); // R5
   AST_RESUME_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[IDX_RSU] && !(resume_i && in_suspend_i)) |=> !flags[IDX_RSU]); // R6
   AST_SUSPEND_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[IDX_SUS] && !(suspend_sig_i && susp_det_en_i)) |=> !flags[IDX_SUS]); // R7
   AST_SOF_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[IDX_SOF] && !sof_tok_i && !tmr_run) |=> !flags[IDX_SOF]); // R8
endmodule

// File: tb/test_usb_evt_flags.sv
`timescale 1ns/1ps
module test_usb_evt_flags;
   localparam int FRAME = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sof_tok_i = 1'b0, bus_rst_i = 1'b0, resume_i = 1'b0, suspend_sig_i = 1'b0;
   logic       in_suspend_i = 1'b0, susp_det_en_i = 1'b0;
   logic       rd_en_i = 1'b0;
   logic [7:0] rd_addr_i = 8'h00;
   logic [7:0] rd_data_o;
   logic       irq_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #2.5 clk = ~clk;

   usb_evt_flags #(.FRAME_CYCLES(FRAME)) i_usb_evt_flags (
      .clk(clk), .rst_n(rst_n), .sof_tok_i(sof_tok_i), .bus_rst_i(bus_rst_i),
      .resume_i(resume_i), .suspend_sig_i(suspend_sig_i), .in_suspend_i(in_suspend_i),
      .susp_det_en_i(susp_det_en_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
      .rd_data_o(rd_data_o), .irq_o(irq_o)
   );

   task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   // all driver tasks start and end just after a falling edge
   task automatic rd_reg(logic [7:0] addr, logic [7:0] exp, string tag);
      rd_en_i = 1'b1; rd_addr_i = addr;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      rd_en_i = 1'b0;
   endtask

   task automatic pulse(ref logic sig);
      sig = 1'b1;
      @(negedge clk);
      sig = 1'b0;
   endtask

   // monitor: note a strobe at the rising edge, compare just after it
   always @(posedge clk) begin
      automatic bit hit = rd_en_i;
      #1;
      if (hit) begin
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: unexpected read data %02h expected none", rd_data_o);
         end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(t, rd_data_o, e);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 100000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 irq after reset", {7'd0, irq_o}, 8'h00);
      rd_reg(8'h06, 8'h00, "R2 reset flags");
      repeat (100) @(negedge clk);
      rd_reg(8'h06, 8'h00, "R8 timer idle before token");

      pulse(bus_rst_i);
      check("R11 irq with flag", {7'd0, irq_o}, 8'h01);
      rd_reg(8'h06, 8'h04, "R5 bus reset flag");
      check("R3 irq after clearing read", {7'd0, irq_o}, 8'h00);

      pulse(bus_rst_i);
      rd_reg(8'h05, 8'h00, "R1 foreign address reads zero");
      check("R1 foreign read keeps flags", {7'd0, irq_o}, 8'h01);
      rd_reg(8'h06, 8'h04, "R3 flags kept then read");

      pulse(bus_rst_i);
      rd_en_i = 1'b1; rd_addr_i = 8'h06; bus_rst_i = 1'b1;
      exp_q.push_back(8'h04); tag_q.push_back("R4 read returns old value");
      @(negedge clk);
      rd_en_i = 1'b0; bus_rst_i = 1'b0;
      check("R4 event kept over read", {7'd0, irq_o}, 8'h01);
      rd_reg(8'h06, 8'h04, "R4 event flag after read");

      pulse(resume_i);
      rd_reg(8'h06, 8'h00, "R6 resume ignored when awake");
      in_suspend_i = 1'b1;
      @(negedge clk);
      pulse(resume_i);
      rd_reg(8'h06, 8'h02, "R6 resume in suspend");
      in_suspend_i = 1'b0;

      pulse(suspend_sig_i);
      rd_reg(8'h06, 8'h00, "R7 suspend ignored when disabled");
      susp_det_en_i = 1'b1;
      pulse(suspend_sig_i);
      rd_reg(8'h06, 8'h01, "R7 suspend with detect on");
      susp_det_en_i = 1'b0;

      // token at edge E0; expiry at E40, then E80
      pulse(sof_tok_i);
      rd_reg(8'h06, 8'h08, "R8 token sets flag");
      repeat (38) @(negedge clk);
      check("R9 no flag before period end", {7'd0, irq_o}, 8'h00);
      @(negedge clk);
      check("R9 flag at period end", {7'd0, irq_o}, 8'h01);
      rd_reg(8'h06, 8'h08, "R9 missed token flag");
      repeat (38) @(negedge clk);
      check("R9 no flag before second end", {7'd0, irq_o}, 8'h00);
      @(negedge clk);
      check("R9 second period flag", {7'd0, irq_o}, 8'h01);
      rd_reg(8'h06, 8'h08, "R9 second missed token");

      // restart: new token before expiry moves the deadline
      repeat (20) @(negedge clk);
      pulse(sof_tok_i);
      rd_reg(8'h06, 8'h08, "R9 restart token flag");
      repeat (20) @(negedge clk);
      check("R9 restart moves deadline", {7'd0, irq_o}, 8'h00);
      pulse(bus_rst_i);
      rd_reg(8'h06, 8'h04, "R10 reset only");
      repeat (100) @(negedge clk);
      rd_reg(8'h06, 8'h00, "R10 timer stopped by bus reset");

      pulse(sof_tok_i);
      rd_reg(8'h06, 8'h08, "R8 token before suspend");
      in_suspend_i = 1'b1;
      repeat (100) @(negedge clk);
      rd_reg(8'h06, 8'h00, "R10 timer stopped by suspend");
      in_suspend_i = 1'b0;

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_cmp++; n_bad++;
         $display("FAIL scoreboard: %0d reads pending expected 0", exp_q.size());
      end
      finish_run();
   end
endmodule